// File: doc/BRIEF.md
# Serially Programmed Reference Divider

This block sits in the reference path of a synthesizer. It takes a 16-bit configuration word shifted in MSB first on a slow serial clock while an active-low frame enable is held low. The three most significant bits pick how the reference output is formed. The thirteen least significant bits give the divide ratio of a down-counter. That counter emits a single-cycle pulse to a downstream phase detector once per count cycle.

The ratio is double buffered. A complete 16-bit frame writes the ratio only into a holding register. A separate enable pulse, sent with no serial clocks and with the serial clock low, copies the holding register into the active register. The counter picks up the new active ratio only when its current count cycle runs out, so the pulse train never carries a shortened or stretched cycle. All serial lines are sampled in the reference clock domain `clk_i`, which also serves as the reference input.

Top module: `ref_div_top`

## Requirements
- R1: After reset the active ratio is 8 (first `pd_ref_o` pulse 7 cycles after reset release, then one every 8 cycles), the mode is 6, `xtal_en_o` is 0 and `ref_o` is 0.
- R2: Serial bits are sampled on rising edges of `ser_clk_i` while `ser_en_ni` is low, MSB first. Word bits 15..13 are the mode field and bits 12..0 are the ratio field. When `ser_en_ni` rises after exactly 16 serial clocks, the mode field takes effect on the following clock.
- R3: A 16-bit frame writes the ratio field only into the holding register, and the `pd_ref_o` period does not change.
- R4: A commit is a rise of `ser_en_ni` with zero serial clocks in the frame while `ser_clk_i` is low. It copies the holding register into the active register and leaves the holding register unchanged, so a repeated commit gives the same ratio.
- R5: After a commit, the count cycle in progress completes at the old ratio, and the new ratio governs the cycles after it.
- R6: A holding value of 0, 2, 3 or 4 is rejected at commit, and the active ratio keeps its previous value.
- R7: Ratio 1 bypasses the counter: `pd_ref_o` is high on every clock.
- R8: A frame of 1 to 15 or more than 16 serial clocks is discarded, and neither the mode, the holding register nor the active register changes.
- R9: Mode encoding: 0 gives `ref_o` low with `xtal_en_o` 0; 1 gives `ref_o` low with `xtal_en_o` 1; 2 gives `ref_o` low; 3 makes `ref_o` follow `clk_i`. In modes 4, 5, 6 and 7, `ref_o` is bit 0, 1, 2 or 3 respectively of a 4-bit count of `clk_i` rising edges since reset, which divides the input by 2, 4, 8 or 16. `xtal_en_o` is 1 only in mode 1.
- R10: For a ratio N of 5 or more, `pd_ref_o` is high for exactly one clock in every N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled in `clk_i` domain |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_en_ni | input | 1 | Active-low frame enable |
| ref_o | output | 1 | Reference output formed per mode |
| xtal_en_o | output | 1 | Oscillator enable, high in mode 1 |
| pd_ref_o | output | 1 | One-cycle pulse to the phase detector per count cycle |

## Verification
The bench places a commit in the middle of a count cycle and expects one more gap at the old ratio. A design that reloaded at once would show a short gap. It commits illegal ratios (3 and 0) and frames of 15 and 17 bits, and then checks that the pulse spacing and the oscillator enable stay put. A design that decoded these would change period or mode. It also commits ratio 1 after a longer ratio, where a counter that mishandled the reload would drop pulses. It steps through every mode and compares `ref_o` with a behavioural model on every clock, so a wrong prescaler tap or a wrong pass-through phase in mode 3 shows up at once.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_XTAL_OFF = 3'd0,
    MODE_XTAL_ON  = 3'd1,
    MODE_REF_LOW  = 3'd2,
    MODE_REF_THRU = 3'd3,
    MODE_DIV2     = 3'd4,
    MODE_DIV4     = 3'd5,
    MODE_DIV8     = 3'd6,
    MODE_DIV16    = 3'd7
  } mode_e;
endpackage

// File: rtl/ref_div_serial.sv
module ref_div_serial #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_en_ni,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o,
  output logic              commit_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic              sclk_q, en_q;
  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  bits_q;
  logic              sclk_rise, en_rise;

  assign sclk_rise = ser_clk_i & ~sclk_q;
  assign en_rise   = ser_en_ni & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b1;
      sh_q   <= '0;
      bits_q <= '0;
    end else begin
      sclk_q <= ser_clk_i;
      en_q   <= ser_en_ni;
      if (ser_en_ni) begin
        bits_q <= '0;
      end else if (sclk_rise) begin
        sh_q <= {sh_q[WORD_W-2:0], ser_data_i};
        if (bits_q != OVER) bits_q <= bits_q + 1'b1;  // saturate: long frames stay invalid
      end
    end
  end

  assign word_o   = sh_q;
  assign load_o   = en_rise && (bits_q == FULL);
  assign commit_o = en_rise && (bits_q == '0) && !ser_clk_i;
endmodule

// File: rtl/ref_div_ratio.sv
module ref_div_ratio #(
  parameter int RATIO_W   = 13,
  parameter int RST_RATIO = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               commit_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [RATIO_W-1:0] hold_o,
  output logic [RATIO_W-1:0] act_o,
  output logic               tc_o
);
  localparam logic [RATIO_W-1:0] RST_VAL = RATIO_W'(RST_RATIO);
  localparam logic [RATIO_W-1:0] MIN_CNT = RATIO_W'(5);

  logic [RATIO_W-1:0] hold_q, act_q, cnt_q;
  logic               hold_legal;

  assign hold_legal = (hold_q == RATIO_W'(1)) || (hold_q >= MIN_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= RST_VAL;
      act_q  <= RST_VAL;
      cnt_q  <= RST_VAL - 1'b1;
    end else begin
      if (load_i) hold_q <= ratio_i;
      if (commit_i && hold_legal) act_q <= hold_q;
      // reload uses the pre-edge active ratio: switch lands on a cycle boundary
      if (cnt_q == '0) cnt_q <= act_q - 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign hold_o = hold_q;
  assign act_o  = act_q;
  assign tc_o   = (cnt_q == '0);
endmodule

// File: rtl/ref_div_outmux.sv
module ref_div_outmux
  import ref_div_pkg::*;
#(
  parameter int RST_MODE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              ref_o,
  output logic              xtal_en_o
);
  localparam int PRE_W = (1 << MODE_W) - 4;

  mode_e             mode_q;
  logic [PRE_W-1:0]  pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= mode_e'(RST_MODE);
      pre_q  <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (load_i) mode_q <= mode_e'(mode_i);
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_REF_THRU:                           ref_o = clk_i;
      MODE_DIV2, MODE_DIV4, MODE_DIV8, MODE_DIV16: ref_o = pre_q[mode_q[1:0]];
      default:                                 ref_o = 1'b0;
    endcase
  end

  assign xtal_en_o = (mode_q == MODE_XTAL_ON);
  assign mode_o    = mode_q;
endmodule

// File: rtl/ref_div_top.sv
module ref_div_top
  import ref_div_pkg::*;
#(
  parameter int RATIO_W   = 13,
  parameter int RST_RATIO = 8,
  parameter int RST_MODE  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  input  logic ser_en_ni,
  output logic ref_o,
  output logic xtal_en_o,
  output logic pd_ref_o
);
  localparam int WORD_W = MODE_W + RATIO_W;

  logic [WORD_W-1:0]  word;
  logic               load_p, commit_p;
  logic [RATIO_W-1:0] hold_ratio, act_ratio;
  logic [MODE_W-1:0]  mode_w;

  ref_div_serial #(.WORD_W(WORD_W)) u_ser (
    .clk_i, .rst_ni, .ser_clk_i, .ser_data_i, .ser_en_ni,
    .word_o(word), .load_o(load_p), .commit_o(commit_p)
  );

  ref_div_ratio #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO)) u_ratio (
    .clk_i, .rst_ni, .load_i(load_p), .commit_i(commit_p),
    .ratio_i(word[RATIO_W-1:0]), .hold_o(hold_ratio), .act_o(act_ratio),
    .tc_o(pd_ref_o)
  );

  ref_div_outmux #(.RST_MODE(RST_MODE)) u_out (
    .clk_i, .rst_ni, .load_i(load_p), .mode_i(word[WORD_W-1 -: MODE_W]),
    .mode_o(mode_w), .ref_o, .xtal_en_o
  );
endmodule

// File: rtl/ref_div_chk.sv
module ref_div_chk #(
  parameter int RATIO_W = 13,
  parameter int MODE_W  = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_p,
  input logic               commit_p,
  input logic [RATIO_W-1:0] hold_ratio,
  input logic [RATIO_W-1:0] act_ratio,
  input logic [MODE_W-1:0]  mode_w,
  input logic               pd_ref_o,
  input logic               ref_o,
  input logic               xtal_en_o
);
  a_r3_load_keeps_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_p |=> $stable(act_ratio));

  a_r4_commit_keeps_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_p |=> $stable(hold_ratio));

  a_r6_active_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ratio == RATIO_W'(1)) || (act_ratio >= RATIO_W'(5)));

  a_r7_bypass_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ref_o && act_ratio == RATIO_W'(1)) |=> pd_ref_o);

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ref_o && act_ratio > RATIO_W'(1)) |=> !pd_ref_o);

  a_r9_low_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w <= MODE_W'(2)) |-> (!ref_o && (xtal_en_o == (mode_w == MODE_W'(1)))));
endmodule

bind ref_div_top ref_div_chk #(.RATIO_W(RATIO_W), .MODE_W(ref_div_pkg::MODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_p(load_p), .commit_p(commit_p),
  .hold_ratio(hold_ratio), .act_ratio(act_ratio), .mode_w(mode_w),
  .pd_ref_o(pd_ref_o), .ref_o(ref_o), .xtal_en_o(xtal_en_o)
);

// File: tb/ref_div_top_tb_top.sv
`timescale 1ns/1ps
module ref_div_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sen_n = 1'b1;
  logic ref_o, xtal_en_o, pd_ref_o;
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  ref_div_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
    .ser_en_ni(sen_n), .ref_o(ref_o), .xtal_en_o(xtal_en_o), .pd_ref_o(pd_ref_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model
  int   m_mode, m_hold, m_act, m_left, m_pre, m_bits;
  logic [15:0] m_sh;
  logic m_sclk_prev, m_en_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 6; m_hold = 8; m_act = 8; m_left = 7; m_pre = 0; m_bits = 0;
      m_sh = '0; m_sclk_prev = 1'b0; m_en_prev = 1'b1;
    end else begin
      bit s_rise, e_rise;
      int bits_old;
      s_rise = sclk && !m_sclk_prev;
      e_rise = sen_n && !m_en_prev;
      bits_old = m_bits;
      m_pre = (m_pre + 1) % 16;
      if (m_left == 0) m_left = m_act - 1; else m_left--;
      if (e_rise && bits_old == 0 && !sclk && (m_hold == 1 || m_hold >= 5)) m_act = m_hold;
      if (e_rise && bits_old == 16) begin
        m_mode = m_sh[15:13];
        m_hold = m_sh[12:0];
      end
      if (sen_n) m_bits = 0;
      else if (s_rise) begin
        m_sh = {m_sh[14:0], sdat};
        m_bits++;
      end
      m_sclk_prev = sclk; m_en_prev = sen_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      int exp_ref;
      #5;
      if (m_mode <= 2) exp_ref = 0;
      else if (m_mode == 3) exp_ref = 1;
      else exp_ref = (m_pre >> (m_mode - 4)) & 1;
      chk(pd_ref_o == (m_left == 0), "R10 pd_ref model", pd_ref_o, m_left == 0);
      chk(ref_o == exp_ref, "R9 ref_o model", ref_o, exp_ref);
      chk(xtal_en_o == (m_mode == 1), "R9 xtal_en model", xtal_en_o, m_mode == 1);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int mode, input int ratio, input int nbits);
    logic [15:0] w;
    w = {mode[2:0], ratio[12:0]};
    @(negedge clk); sen_n = 1'b0; tick(1);
    for (int i = 0; i < nbits; i++) begin
      sdat = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(2);
    end
    sen_n = 1'b1; tick(2);
  endtask

  task automatic commit();
    @(negedge clk); sen_n = 1'b0; tick(2);
    sen_n = 1'b1; tick(2);
  endtask

  task automatic wait_pulse();
    do begin @(posedge clk); #5; end while (!pd_ref_o);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(posedge clk); #5; n++; end while (!pd_ref_o && n < 10000);
  endtask

  task automatic gap_chk(input int exp, input string tag);
    int n;
    wait_pulse();
    gap(n);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic commit_settle(input int exp, input string tag);
    commit();
    wait_pulse();
    gap_chk(exp, tag);
  endtask

  initial begin
    int n;
    tick(3);
    chk(pd_ref_o == 0, "R1 pd_ref after reset", pd_ref_o, 0);
    chk(xtal_en_o == 0, "R1 xtal_en after reset", xtal_en_o, 0);
    chk(ref_o == 0, "R1 ref_o after reset", ref_o, 0);
    #5 rst_n = 1'b1;
    gap(n);
    chk(n == 7, "R1 first pulse delay", n, 7);
    gap_chk(8, "R1 reset ratio 8");

    // R2/R3: load mode 1 and ratio 12, period unchanged
    send(1, 12, 16);
    chk(xtal_en_o == 1, "R2 mode field applied", xtal_en_o, 1);
    gap_chk(8, "R3 load leaves active ratio");

    // R5: commit mid-cycle, old gap completes first
    wait_pulse();
    fork
      commit();
      begin gap(n); chk(n == 8, "R5 current cycle at old ratio", n, 8); end
    join
    wait_pulse();
    gap_chk(12, "R4 committed ratio 12");
    commit_settle(12, "R4 repeat commit keeps holding");

    // R6: illegal ratios rejected
    send(7, 3, 16);
    commit_settle(12, "R6 ratio 3 rejected");
    send(7, 0, 16);
    commit_settle(12, "R6 ratio 0 rejected");

    // R8: malformed frames discarded
    send(7, 9, 16);
    commit_settle(9, "R8 setup ratio 9");
    send(1, 20, 15);
    chk(xtal_en_o == 0, "R8 15-bit frame mode kept", xtal_en_o, 0);
    commit_settle(9, "R8 15-bit frame ratio kept");
    send(1, 20, 17);
    chk(xtal_en_o == 0, "R8 17-bit frame mode kept", xtal_en_o, 0);
    commit_settle(9, "R8 17-bit frame ratio kept");

    // R7: bypass
    send(4, 1, 16);
    commit();
    repeat (20) @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #5;
      chk(pd_ref_o == 1, "R7 bypass pulse every cycle", pd_ref_o, 1);
    end

    // R10: minimum counted ratio
    send(5, 5, 16);
    commit();
    repeat (20) @(posedge clk);
    gap_chk(5, "R10 ratio 5 period");
    @(posedge clk); #5;
    chk(pd_ref_o == 0, "R10 pulse one cycle wide", pd_ref_o, 1'b0);

    // R9: walk all modes, model compares each cycle
    for (int md = 0; md < 8; md++) begin
      send(md, 5, 16);
      repeat (40) @(posedge clk);
      if (md == 3) begin
        @(negedge clk); #5;
        chk(ref_o == 0, "R9 mode 3 follows clock low", ref_o, 0);
        @(posedge clk); #5;
        chk(ref_o == 1, "R9 mode 3 follows clock high", ref_o, 1);
      end
      if (md == 2) begin
        @(posedge clk); #5;
        chk(ref_o == 0, "R9 mode 2 static low", ref_o, 0);
      end
    end

    tick(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule